// File: doc/BRIEF.md
# Power-Management Serial Command Channel

This block is a register-mapped command channel. It sits between a CPU register bus and the back end of a serial bus to power-management devices. Software first writes a write-data register and then a 32-bit command word. The channel latches the command and raises a request to the back end. It holds every command field and the write data stable until the back end acknowledges.

Writes finish without software help. After the acknowledge, the channel passes through a one-cycle settling state and then becomes idle again. Reads go another way. The returned bytes are captured into a read-data register, least significant byte first, with every byte beyond the byte count cleared. The channel then stays in a wait-for-clear state until software writes a 1 to the clear register.

A status word exposes the channel state, a sticky error flag and an initialisation-done flag. Software polls the status word for the idle state before it issues the next command. A command written while the channel is busy is dropped, and the error flag records the drop.

Top module: `pmic_cmd_channel`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the channel is idle, `be_req` is 0, the error flag is 0, initialisation-done is 0, and `reg_rdata` and the captured read data are 0.
- R2: Word offsets on `reg_addr`: 0 status, 1 command, 2 write data, 3 read data, 4 valid-clear. A read with `reg_ren` high returns the addressed word on `reg_rdata` after the next rising edge and holds it until the next read. Reading offset 1 returns the last accepted command, offset 2 the last write-data value, and offsets 4 and above return 0.
- R3: Status word layout: bits [3:1] hold the state (idle=0, request=1, wait-for-idle=2, wait-for-clear=3), bit 8 is the error flag, bit 15 is initialisation-done, and all other bits are 0.
- R4: A command write in the idle state is accepted, and the channel is in the request state on the next cycle. The command is decoded as class [31:30] (0 register-zero write, 1 register, 2 extended, 3 extended-long), write flag bit 29 (1 = write), slave ID [28:24], byte count minus one [23:16] and register address [15:0]. These fields drive `be_class`, `be_write`, `be_sid`, `be_bcnt` and `be_addr`.
- R5: In the request state `be_req` is 1. The command fields and `be_wdata` hold still until `be_ack` is sampled high.
- R6: `be_wdata` is the write-data register as it stood when the command was accepted, with byte lanes at or above (byte count mod 4)+1 forced to 0. An acknowledged write spends exactly one cycle in wait-for-idle and then returns to idle.
- R7: An acknowledged read captures `be_rdata` into the read-data register and enters wait-for-clear. Byte lane i (bits 8i+7:8i, least significant first) is kept only when i <= (byte count mod 4); all other lanes read 0.
- R8: Wait-for-clear lasts until offset 4 is written with bit 0 set, and the next state is idle. Writing offset 4 with bit 0 clear, or writing it in any other state, has no effect.
- R9: A command write in any state other than idle is ignored, so the latched command and the back-end fields are unchanged. It sets the error flag, which stays set until reset.
- R10: Initialisation-done goes high after INIT_CYCLES rising edges following the release of reset, and stays high.
- R11: Writes to offset 2 made while a command is in flight do not change `be_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read-back data |
| be_req | output | 1 | Request to the serial back end |
| be_class | output | 2 | Command class |
| be_write | output | 1 | 1 for a write command, 0 for a read |
| be_sid | output | 5 | Slave ID |
| be_bcnt | output | 8 | Byte count minus one |
| be_addr | output | 16 | Device register address |
| be_wdata | output | 32 | Write data, unused lanes zeroed |
| be_ack | input | 1 | Back-end acknowledge, sampled in the request state |
| be_rdata | input | 32 | Back-end read data, valid with be_ack |

## Verification
The assertions assume one register access per cycle, since the write and read strobes share `reg_addr`. They also assume that `be_ack` matters only while `be_req` is high and that `be_rdata` is valid in the cycle `be_ack` is sampled. The bench keeps to these assumptions. It pulses `be_ack` for a single cycle, and only after `be_req` has been seen. It presents `be_rdata` together with the acknowledge. It issues register accesses one per cycle from tasks. Busy-state command writes and clear writes with bit 0 low are issued on purpose, because the design must ignore them.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int WORD_W   = 32;
  localparam int NREGS    = 5;
  localparam int OFF_STATUS = 0;
  localparam int OFF_CMD    = 1;
  localparam int OFF_WDATA  = 2;
  localparam int OFF_RDATA  = 3;
  localparam int OFF_VCLR   = 4;
  localparam int ST_LSB   = 1;
  localparam int ERR_BIT  = 8;
  localparam int INIT_BIT = 15;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_REQ       = 3'd1,
    ST_WAIT_IDLE = 3'd2,
    ST_WAIT_VCLR = 3'd3
  } chan_state_e;

  typedef struct packed {
    logic [1:0]  cls;
    logic        wr;
    logic [4:0]  sid;
    logic [7:0]  bcnt;
    logic [15:0] addr;
  } cmd_word_t;
endpackage

// File: rtl/pcc_lane_mask.sv
module pcc_lane_mask #(
  parameter int NBYTES = 4
) (
  input  logic [$clog2(NBYTES)-1:0] last_lane,
  input  logic [NBYTES*8-1:0]       din,
  output logic [NBYTES*8-1:0]       dout
);
  localparam int LW = $clog2(NBYTES);
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign dout[8*i +: 8] = (LW'(i) <= last_lane) ? din[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/pcc_init_timer.sv
module pcc_init_timer #(
  parameter int INIT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  output logic done
);
  localparam int CW = (INIT_CYCLES < 1) ? 1 : $clog2(INIT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(INIT_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q == LIMIT);

  assert_init_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  assert_init_bound_R10: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);
endmodule

// File: rtl/pcc_regdec.sv
module pcc_regdec
  import pcc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wen,
  input  logic              reg_ren,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              wbit0,
  input  logic [WORD_W-1:0] status_w,
  input  logic [WORD_W-1:0] cmd_w,
  input  logic [WORD_W-1:0] wdata_w,
  input  logic [WORD_W-1:0] rdata_w,
  output logic              cmd_wr,
  output logic              wdata_wr,
  output logic              vclr_wr,
  output logic [WORD_W-1:0] reg_rdata
);
  logic [NREGS-1:0] hit;

  for (genvar i = 0; i < NREGS; i++) begin : g_hit
    assign hit[i] = (reg_addr == ADDR_W'(i));
  end

  assign cmd_wr   = reg_wen && hit[OFF_CMD];
  assign wdata_wr = reg_wen && hit[OFF_WDATA];
  assign vclr_wr  = reg_wen && hit[OFF_VCLR] && wbit0;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_ren) begin
      if (hit[OFF_STATUS])     reg_rdata <= status_w;
      else if (hit[OFF_CMD])   reg_rdata <= cmd_w;
      else if (hit[OFF_WDATA]) reg_rdata <= wdata_w;
      else if (hit[OFF_RDATA]) reg_rdata <= rdata_w;
      else                     reg_rdata <= '0;
    end
  end

  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !reg_ren |=> $stable(reg_rdata));
  assert_status_read_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_ren && hit[OFF_STATUS]) |=> (reg_rdata == $past(status_w)));
endmodule

// File: rtl/pcc_fsm.sv
module pcc_fsm
  import pcc_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              wdata_wr,
  input  logic              vclr_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              be_ack,
  input  logic [WORD_W-1:0] be_rdata,
  output chan_state_e       state_q,
  output cmd_word_t         cmd_q,
  output logic [WORD_W-1:0] wdata_q,
  output logic [WORD_W-1:0] snap_q,
  output logic [WORD_W-1:0] rdata_q,
  output logic              err_q
);
  localparam int LW = $clog2(NBYTES);

  cmd_word_t         cmd_in;
  logic [WORD_W-1:0] wmasked;
  logic [WORD_W-1:0] rmasked;

  assign cmd_in = cmd_word_t'(bus_wdata);

  pcc_lane_mask #(.NBYTES(NBYTES)) u_wmask (
    .last_lane (cmd_in.bcnt[LW-1:0]),
    .din       (wdata_q),
    .dout      (wmasked)
  );

  pcc_lane_mask #(.NBYTES(NBYTES)) u_rmask (
    .last_lane (cmd_q.bcnt[LW-1:0]),
    .din       (be_rdata),
    .dout      (rmasked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      wdata_q <= '0;
      snap_q  <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (wdata_wr) wdata_q <= bus_wdata;
      if (cmd_wr && state_q != ST_IDLE) err_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_wr) begin
            cmd_q   <= cmd_in;
            snap_q  <= wmasked;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (be_ack) begin
            if (cmd_q.wr) begin
              state_q <= ST_WAIT_IDLE;
            end else begin
              rdata_q <= rmasked;
              state_q <= ST_WAIT_VCLR;
            end
          end
        end
        ST_WAIT_IDLE: state_q <= ST_IDLE;
        ST_WAIT_VCLR: if (vclr_wr) state_q <= ST_IDLE;
        default:      state_q <= ST_IDLE;
      endcase
    end
  end

  assert_accept_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && cmd_wr) |=> (state_q == ST_REQ));
  assert_idle_stay_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !cmd_wr) |=> (state_q == ST_IDLE));
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REQ && !be_ack) |=>
      (state_q == ST_REQ && $stable(cmd_q) && $stable(snap_q)));
  assert_write_settle_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_IDLE) |=> (state_q == ST_IDLE));
  assert_read_lane0_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_VCLR && cmd_q.bcnt[LW-1:0] == '0) |->
      (rdata_q[WORD_W-1:8] == '0));
  assert_vclr_wait_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_VCLR && !vclr_wr) |=>
      (state_q == ST_WAIT_VCLR && $stable(rdata_q)));
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && cmd_wr) |=> (err_q && $stable(cmd_q)));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
  assert_snap_keep_R11: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> $stable(snap_q));
endmodule

// File: rtl/pmic_cmd_channel.sv
module pmic_cmd_channel
  import pcc_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int NBYTES      = 4,
  parameter int INIT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wen,
  input  logic              reg_ren,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              be_req,
  output logic [1:0]        be_class,
  output logic              be_write,
  output logic [4:0]        be_sid,
  output logic [7:0]        be_bcnt,
  output logic [15:0]       be_addr,
  output logic [31:0]       be_wdata,
  input  logic              be_ack,
  input  logic [31:0]       be_rdata
);
  chan_state_e       state_q;
  cmd_word_t         cmd_q;
  logic [WORD_W-1:0] wdata_q, snap_q, rdata_q, status_w;
  logic              err_q, init_done;
  logic              cmd_wr, wdata_wr, vclr_wr;

  pcc_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk  (clk),
    .rst  (rst),
    .done (init_done)
  );

  pcc_regdec #(.ADDR_W(ADDR_W)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .reg_wen   (reg_wen),
    .reg_ren   (reg_ren),
    .reg_addr  (reg_addr),
    .wbit0     (reg_wdata[0]),
    .status_w  (status_w),
    .cmd_w     (WORD_W'(cmd_q)),
    .wdata_w   (wdata_q),
    .rdata_w   (rdata_q),
    .cmd_wr    (cmd_wr),
    .wdata_wr  (wdata_wr),
    .vclr_wr   (vclr_wr),
    .reg_rdata (reg_rdata)
  );

  pcc_fsm #(.NBYTES(NBYTES)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .wdata_wr  (wdata_wr),
    .vclr_wr   (vclr_wr),
    .bus_wdata (reg_wdata),
    .be_ack    (be_ack),
    .be_rdata  (be_rdata),
    .state_q   (state_q),
    .cmd_q     (cmd_q),
    .wdata_q   (wdata_q),
    .snap_q    (snap_q),
    .rdata_q   (rdata_q),
    .err_q     (err_q)
  );

  always_comb begin
    status_w               = '0;
    status_w[ST_LSB +: 3]  = state_q;
    status_w[ERR_BIT]      = err_q;
    status_w[INIT_BIT]     = init_done;
  end

  assign be_req   = (state_q == ST_REQ);
  assign be_class = cmd_q.cls;
  assign be_write = cmd_q.wr;
  assign be_sid   = cmd_q.sid;
  assign be_bcnt  = cmd_q.bcnt;
  assign be_addr  = cmd_q.addr;
  assign be_wdata = snap_q;

  assert_req_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (be_req && !be_ack) |=> be_req);
  assert_status_zero_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(status_w & ~32'h0000_810E) == 0);
endmodule

// File: tb/pmic_cmd_channel_tb.sv
module pmic_cmd_channel_tb;
  localparam int INIT = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wen = 1'b0, reg_ren = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        be_req, be_write, be_ack = 1'b0;
  logic [1:0]  be_class;
  logic [4:0]  be_sid;
  logic [7:0]  be_bcnt;
  logic [15:0] be_addr;
  logic [31:0] be_wdata, be_rdata = '0;

  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  pmic_cmd_channel #(.ADDR_W(3), .NBYTES(4), .INIT_CYCLES(INIT)) u_dut (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_ren(reg_ren),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .be_req(be_req), .be_class(be_class), .be_write(be_write),
    .be_sid(be_sid), .be_bcnt(be_bcnt), .be_addr(be_addr),
    .be_wdata(be_wdata), .be_ack(be_ack), .be_rdata(be_rdata)
  );

  // ---------------- behavioural reference model ----------------
  int          m_st, m_cnt;
  bit          m_err, m_cmdw, m_busy;
  logic [31:0] m_cmd, m_wd, m_snap, m_rd, m_rb, m_stw;

  function automatic logic [31:0] keep_bytes(logic [31:0] v, int bc);
    int n = (bc % 4) + 1;
    for (int i = 0; i < 4; i++) if (i >= n) v[8*i +: 8] = 8'h00;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_err = 0;
      m_cmd = 0; m_wd = 0; m_snap = 0; m_rd = 0; m_rb = 0;
    end else begin
      m_stw = ((m_cnt == INIT) ? 32'h8000 : 32'h0) |
              (m_err ? 32'h100 : 32'h0) | (32'(m_st) << 1);
      if (reg_ren) begin
        case (reg_addr)
          3'd0: m_rb = m_stw;
          3'd1: m_rb = m_cmd;
          3'd2: m_rb = m_wd;
          3'd3: m_rb = m_rd;
          default: m_rb = 0;
        endcase
      end
      if (m_cnt < INIT) m_cnt++;
      m_cmdw = reg_wen && reg_addr == 3'd1;
      m_busy = (m_st != 0);
      if (m_cmdw && m_busy) m_err = 1;
      case (m_st)
        0: if (m_cmdw) begin
             m_cmd = reg_wdata; m_snap = keep_bytes(m_wd, int'(reg_wdata[17:16])); m_st = 1;
           end
        1: if (be_ack) begin
             if (m_cmd[29]) m_st = 2;
             else begin m_rd = keep_bytes(be_rdata, int'(m_cmd[17:16])); m_st = 3; end
           end
        2: m_st = 0;
        default: if (reg_wen && reg_addr == 3'd4 && reg_wdata[0]) m_st = 0;
      endcase
      if (reg_wen && reg_addr == 3'd2) m_wd = reg_wdata;
    end
  end

  // per-cycle comparison of every output against the model (R2, R4, R5, R6)
  always @(posedge clk) begin
    #2;
    n_chk++;
    if (reg_rdata !== m_rb || be_req !== (m_st == 1) ||
        {be_class, be_write, be_sid, be_bcnt, be_addr} !== m_cmd ||
        be_wdata !== m_snap) begin
      n_err++;
      $display("FAIL R2/R4/R5/R6 model compare t=%0t act rd=%h req=%b cmd=%h wd=%h exp rd=%h req=%b cmd=%h wd=%h",
               $time, reg_rdata, be_req, {be_class, be_write, be_sid, be_bcnt, be_addr},
               be_wdata, m_rb, (m_st == 1), m_cmd, m_snap);
    end
  end

  // ---------------- tasks ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic bus_rd(input int a, output logic [31:0] v);
    @(negedge clk);
    reg_ren = 1'b1; reg_addr = 3'(a);
    @(negedge clk);
    reg_ren = 1'b0;
    v = reg_rdata;
  endtask

  task automatic ack(input int dly, input logic [31:0] rd);
    repeat (dly) @(negedge clk);
    be_ack = 1'b1; be_rdata = rd;
    @(negedge clk);
    be_ack = 1'b0;
  endtask

  function automatic logic [31:0] cmdw(int cls, int wr, int sid, int bc, int addr);
    return {2'(cls), 1'(wr), 5'(sid), 8'(bc), 16'(addr)};
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  // ---------------- stimulus ----------------
  logic [31:0] v;
  logic [31:0] lf = 32'h1234_5678;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 be_req after reset", {31'b0, be_req}, 32'h0);
    bus_rd(0, v);  chk("R1 status after reset", v, 32'h0);
    bus_rd(3, v);  chk("R1 read data after reset", v, 32'h0);
    for (int i = 0; i < 16; i++) bus_rd(0, v);   // init edge tracked by model
    chk("R10 init done", v, 32'h0000_8000);

    // write command, 2 bytes
    bus_wr(2, 32'h4433_2211);
    bus_rd(2, v); chk("R2 wdata readback", v, 32'h4433_2211);
    bus_wr(1, cmdw(1, 1, 5, 1, 16'h1234));
    chk("R4 be_req", {31'b0, be_req}, 32'h1);
    chk("R4 fields", {be_class, be_write, be_sid, be_bcnt, be_addr}, cmdw(1, 1, 5, 1, 16'h1234));
    chk("R6 masked wdata", be_wdata, 32'h0000_2211);
    bus_wr(2, 32'hDEAD_BEEF);
    chk("R11 wdata snapshot kept", be_wdata, 32'h0000_2211);
    bus_rd(0, v); chk("R3 status request", v, 32'h0000_8002);
    repeat (3) @(negedge clk);
    chk("R5 request held", {31'b0, be_req}, 32'h1);
    be_ack = 1'b1; reg_ren = 1'b1; reg_addr = 3'd0;
    @(negedge clk); be_ack = 1'b0;
    @(negedge clk); chk("R6 wait-for-idle state", reg_rdata, 32'h0000_8004);
    @(negedge clk); reg_ren = 1'b0;
    chk("R6 back to idle", reg_rdata, 32'h0000_8000);

    // read command, 3 bytes, with a busy command write
    bus_wr(1, cmdw(2, 0, 3, 2, 16'h00AB));
    bus_wr(1, cmdw(3, 1, 9, 0, 16'hFFFF));
    chk("R9 ignored command", {be_class, be_write, be_sid, be_bcnt, be_addr}, cmdw(2, 0, 3, 2, 16'h00AB));
    bus_rd(0, v); chk("R9 error flag", v, 32'h0000_8102);
    ack(1, 32'hAABB_CCDD);
    bus_rd(3, v); chk("R7 read data lanes", v, 32'h00BB_CCDD);
    bus_rd(0, v); chk("R3 status wait-for-clear", v, 32'h0000_8106);
    bus_wr(4, 32'h0000_0000);
    bus_rd(0, v); chk("R8 clear bit0=0 ignored", v, 32'h0000_8106);
    bus_wr(4, 32'h0000_0001);
    bus_rd(0, v); chk("R8 clear returns idle", v, 32'h0000_8100);
    bus_wr(4, 32'h0000_0001);
    bus_rd(0, v); chk("R8 clear in idle no effect", v, 32'h0000_8100);
    bus_rd(1, v); chk("R2 command readback", v, cmdw(2, 0, 3, 2, 16'h00AB));
    bus_rd(5, v); chk("R2 unmapped offset", v, 32'h0);

    // read with full word and with count 4 (one lane)
    bus_wr(1, cmdw(3, 0, 1, 3, 16'h0010));
    ack(0, 32'h1122_3344);
    bus_rd(3, v); chk("R7 four lanes", v, 32'h1122_3344);
    bus_wr(4, 32'h1);
    bus_wr(1, cmdw(2, 0, 1, 4, 16'h0011));
    ack(2, 32'h1122_3344);
    bus_rd(3, v); chk("R7 count 4 keeps one lane", v, 32'h0000_0044);
    bus_wr(4, 32'h1);

    // register-zero write, one byte
    bus_wr(2, 32'hCAFE_F00D);
    bus_wr(1, cmdw(0, 1, 31, 0, 16'h0000));
    chk("R6 single lane write data", be_wdata, 32'h0000_000D);
    ack(0, 32'h0);
    repeat (2) @(negedge clk);

    // pseudo-random commands, checked by the model every cycle
    for (int k = 0; k < 24; k++) begin
      lf = lf * 32'd1664525 + 32'd1013904223;
      bus_wr(2, lf ^ 32'h5A5A_A5A5);
      bus_wr(1, lf);
      ack(int'(lf[3:2]), ~lf);
      if (!lf[29]) begin
        bus_rd(3, v);
        bus_wr(4, {31'b0, lf[5]});
        if (!lf[5]) bus_wr(4, 32'h1);
      end else begin
        repeat (2) @(negedge clk);
      end
      bus_rd(0, v);
    end

    // reset clears error flag
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    bus_rd(0, v); chk("R1 R9 reset clears error", v, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule